// File: doc/BRIEF.md
# Two-Level Token Ring Arbiter

This block decides which pixel station in one readout column may send its hit next. Stations that have nothing to report are never visited, so readout is sparse and needs no trigger. The stations sit in super-pixels. A local token moves among the stations of a super-pixel, and a global token moves among the super-pixels. The column has 64 stations in total with the defaults of 8 stations per super-pixel and 8 super-pixels.

Each station raises its request line while it holds an unread hit. When the arbiter is idle, it grants one requesting station on the next clock edge. It drives a one-hot grant vector, the flat index of the granted station and a valid flag. The grant is held until the downstream transfer pulses release. The tokens then move past the station just served. Everything runs on the single column clock.

Top module: `tok_ring_arb`

## Requirements
- R1: After reset, grant_valid_o is 0 and grant_o is all zero. Both tokens sit at station 0, so with every request line high the first grant goes to index 0.
- R2: A grant is given only to a station whose request was high on the edge that issued it. While no request is pending, grant_valid_o stays 0 and grant_o stays zero.
- R3: While grant_valid_o is 1, grant_o has exactly one bit set, at position grant_idx_o = s*LOCAL_N + l, where s is the super-pixel and l is the local station. While grant_valid_o is 0, grant_o is zero.
- R4: If the arbiter is idle and any request is high at a clock edge, the grant appears at that edge. Stations without a request are skipped in that same step.
- R5: A grant, its index and its valid flag stay unchanged until release_i is sampled high, even if requests change or drop. A release_i pulse while no grant is active has no effect.
- R6: On the edge that samples release_i high, grant_valid_o goes to 0 for one cycle. The next grant can appear on the following edge.
- R7: Within a super-pixel, the search starts at the station after the one last served in that super-pixel and wraps from the last local station to station 0.
- R8: After a release, the global token stays on the current super-pixel if a station with a higher local number there is requesting. Otherwise it moves to the next super-pixel. The search over super-pixels is round robin from the global token and wraps.
- R9: While no request is pending, both token positions are kept, so later grants continue from where arbitration stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | LOCAL_N*GROUP_N | One request line per station, with flat index s*LOCAL_N+l |
| release_i | input | 1 | The downstream transfer of the granted station is done |
| grant_o | output | LOCAL_N*GROUP_N | One-hot grant |
| grant_idx_o | output | clog2(LOCAL_N*GROUP_N) | Flat index of the granted station |
| grant_valid_o | output | 1 | A grant is active |

## Verification
The bench builds the arbiter with the default 8 stations per super-pixel and 8 super-pixels, which gives 64 stations. With this size, a full sweep through one super-pixel and into the next can be driven directly. The size also allows a skip across several empty super-pixels and a wrap of the global token past the last super-pixel. It also reaches a local token that starts mid-group and wraps back to station 0. Grant holding is exercised while requests drop and while new ones arrive, and release pulses are applied while idle.

// File: rtl/tok_ring_arb.sv
module tok_ring_arb #(
  parameter int LOCAL_N = 8,
  parameter int GROUP_N = 8,
  localparam int N  = LOCAL_N * GROUP_N,
  localparam int LW = (LOCAL_N > 1) ? $clog2(LOCAL_N) : 1,
  localparam int GW = (GROUP_N > 1) ? $clog2(GROUP_N) : 1,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic          release_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] grant_idx_o,
  output logic          grant_valid_o
);

  logic [GW-1:0] gptr;
  logic [LW-1:0] lptr [GROUP_N];
  logic          busy;
  logic [GW-1:0] cur_g;
  logic [LW-1:0] cur_l;

  logic [GROUP_N-1:0] grp_any;
  logic               pick_found;
  logic [GW-1:0]      pick_g;
  logic [LW-1:0]      pick_l;
  logic [IW-1:0]      pick_idx;
  logic [LOCAL_N-1:0] pick_vec;
  logic [LOCAL_N-1:0] cur_vec;
  logic               more_hi;
  logic [LW-1:0]      nxt_l;
  logic [GW-1:0]      nxt_g;

  for (genvar g = 0; g < GROUP_N; g++) begin : g_any
    assign grp_any[g] = |req_i[g*LOCAL_N +: LOCAL_N];
  end

  always_comb begin
    int gi;
    pick_found = 1'b0;
    pick_g     = '0;
    for (int k = 0; k < GROUP_N; k++) begin
      gi = (int'(gptr) + k) % GROUP_N;
      if (!pick_found && grp_any[gi]) begin
        pick_found = 1'b1;
        pick_g     = GW'(gi);
      end
    end
  end

  assign pick_vec = req_i[int'(pick_g)*LOCAL_N +: LOCAL_N];

  always_comb begin
    int li;
    logic hit;
    hit    = 1'b0;
    pick_l = '0;
    for (int k = 0; k < LOCAL_N; k++) begin
      li = (int'(lptr[pick_g]) + k) % LOCAL_N;
      if (!hit && pick_vec[li]) begin
        hit    = 1'b1;
        pick_l = LW'(li);
      end
    end
  end

  assign pick_idx = IW'(int'(pick_g) * LOCAL_N + int'(pick_l));
  assign cur_vec  = req_i[int'(cur_g)*LOCAL_N +: LOCAL_N];

  always_comb begin
    more_hi = 1'b0;
    for (int l = 0; l < LOCAL_N; l++)
      if (l > int'(cur_l) && cur_vec[l]) more_hi = 1'b1;
  end

  assign nxt_l = LW'((int'(cur_l) + 1) % LOCAL_N);
  assign nxt_g = more_hi ? cur_g : GW'((int'(cur_g) + 1) % GROUP_N);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      gptr        <= '0;
      cur_g       <= '0;
      cur_l       <= '0;
      grant_o     <= '0;
      grant_idx_o <= '0;
      for (int g = 0; g < GROUP_N; g++) lptr[g] <= '0;
    end else if (busy) begin
      if (release_i) begin
        busy        <= 1'b0;
        grant_o     <= '0;
        lptr[cur_g] <= nxt_l;
        gptr        <= nxt_g;
      end
    end else if (pick_found) begin
      busy        <= 1'b1;
      cur_g       <= pick_g;
      cur_l       <= pick_l;
      grant_idx_o <= pick_idx;
      grant_o     <= {{(N-1){1'b0}}, 1'b1} << pick_idx;
    end
  end

  assign grant_valid_o = busy;

endmodule

module tok_ring_arb_sva #(
  parameter int N  = 64,
  parameter int IW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req_i,
  input logic          release_i,
  input logic [N-1:0]  grant_o,
  input logic [IW-1:0] grant_idx_o,
  input logic          grant_valid_o
);
  logic [N-1:0] req_q;
  always_ff @(posedge clk) req_q <= req_i;

  assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && (grant_valid_o == (grant_o != '0)));

  assert_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |-> grant_o[grant_idx_o]);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o && !release_i |=> grant_valid_o && $stable(grant_o) && $stable(grant_idx_o));

  assert_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o && release_i |=> !grant_valid_o);

  assert_req_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid_o) |-> req_q[grant_idx_o]);

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid_o && (req_i == '0) |=> !grant_valid_o);

  assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid_o && (req_i != '0) |=> grant_valid_o);
endmodule

bind tok_ring_arb tok_ring_arb_sva #(.N(N), .IW(IW)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .release_i(release_i),
  .grant_o(grant_o), .grant_idx_o(grant_idx_o), .grant_valid_o(grant_valid_o)
);

// File: tb/tok_ring_arb_tb.sv
module tok_ring_arb_tb_top;
  localparam int N = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req_i = '0;
  logic         release_i = 1'b0;
  logic [N-1:0] grant_o;
  logic [5:0]   grant_idx_o;
  logic         grant_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tok_ring_arb dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .release_i(release_i),
    .grant_o(grant_o), .grant_idx_o(grant_idx_o), .grant_valid_o(grant_valid_o)
  );

  function automatic logic [N-1:0] bit_at(int i);
    return {{(N-1){1'b0}}, 1'b1} << i;
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_grant(string tag, int exp);
    chk({tag, " valid"}, N'(grant_valid_o), N'(1));
    chk({tag, " index"}, N'(grant_idx_o), N'(exp));
    chk({tag, " onehot"}, grant_o, bit_at(exp));
  endtask

  task automatic chk_idle(string tag);
    chk({tag, " valid"}, N'(grant_valid_o), N'(0));
    chk({tag, " grant"}, grant_o, '0);
  endtask

  task automatic serve(string tag, int exp, logic [N-1:0] next_req);
    chk_grant(tag, exp);
    req_i = next_req;
    release_i = 1'b1;
    @(negedge clk);
    release_i = 1'b0;
    chk_idle({tag, " R6 gap"});
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_idle("R1 reset");
    @(negedge clk);
    chk_idle("R2 no request");
    repeat (3) @(negedge clk);
    chk_idle("R2 still idle");
  endtask

  task automatic t_sweep;
    req_i = '1;
    @(negedge clk);
    chk_grant("R1 first grant station 0", 0);
    for (int k = 0; k < 10; k++)
      serve($sformatf("R8 sweep step %0d", k), k, (k == 9) ? '0 : '1);
    chk_idle("R2 after sweep");
  endtask

  task automatic t_skip;
    req_i = bit_at(20) | bit_at(3);
    @(negedge clk);
    chk_grant("R4 skip to 20", 20);
    serve("R4 served 20", 20, bit_at(20) | bit_at(3));
    serve("R8 global wrap to 3", 3, '0);
    chk_idle("R2 after skip");
  endtask

  task automatic t_hold;
    req_i = bit_at(40);
    @(negedge clk);
    chk_grant("R4 grant 40", 40);
    req_i = '0;
    repeat (2) @(negedge clk);
    chk_grant("R5 hold after drop", 40);
    req_i = bit_at(5);
    repeat (2) @(negedge clk);
    chk_grant("R5 hold with new req", 40);
    serve("R5 release 40", 40, '0);
    repeat (4) @(negedge clk);
    chk_idle("R9 idle");
    release_i = 1'b1;
    @(negedge clk);
    release_i = 1'b0;
    chk_idle("R5 stray release");
    @(negedge clk);
    chk_idle("R5 stray release later");
  endtask

  task automatic t_local_wrap;
    req_i = bit_at(40) | bit_at(41);
    @(negedge clk);
    chk_grant("R9 token kept gives 41", 41);
    serve("R8 leave group", 41, bit_at(40) | bit_at(41));
    serve("R7 local wrap to 40", 40, bit_at(40) | bit_at(41));
    serve("R8 stay in group 41", 41, '0);
    chk_idle("R2 end");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_sweep();
    t_skip();
    t_hold();
    t_local_wrap();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule